// File: doc/BRIEF.md
# Selective ECC Register Shadow Table

This block keeps single-error-correcting, double-error-detecting check codes for a small, chosen set of physical register versions, held in a tagged table that sits beside the register file. Each register write carries a two-bit lifetime prediction. That prediction decides whether the written version gets a table entry and which resident entry it displaces.

On a register read, the data that the register file returns is also presented to the block. If the register number matches a valid entry, the data is checked against the stored code. A correctable error stalls the reading instruction and raises a flush request. It also drives a write-back of the repaired word to the register file. An error that cannot be corrected is flagged instead. Registers that should stay protected, such as global pointers, can be pinned when they are written so that they are never displaced.

Top module: `sel_ecc_shadow`

## Requirements
- R1: On a read that hits a valid entry and has exactly one flipped bit, the same cycle shows err_stall=1, err_flush=1, wb_en=1, and wb_tag/err_tag equal to the read tag. wb_data equals the word that was last written under that tag, and err_port gives the reading port.
- R2: On a read that hits a valid entry and has two flipped bits, the same cycle shows err_uncorr=1, with wb_en=0 and err_stall=0.
- R3: A read whose tag matches no valid entry, or whose data is clean, raises none of err_stall, err_flush, err_uncorr or wb_en.
- R4: A write whose tag is already held overwrites that same entry. Later corrections return the new word, and no second entry is used.
- R5: A write whose tag is not held takes the lowest-numbered invalid entry, if there is one.
- R6: If the table is full, the predicted lifetime is the 2-bit number {used, renamed}, where higher means longer-lived. The write then replaces the unpinned entry with the lowest lifetime that is strictly below its own, and takes the lowest index on a tie.
- R7: If no unpinned entry has a strictly lower lifetime, the incoming version is not protected and the table is unchanged.
- R8: An entry written with pin=1 is never chosen as a victim.
- R9: fr_en invalidates the entry holding fr_tag. Frees take effect before the writes of the same cycle.
- R10: Writes in one cycle are served in order of port number, from port 0 up. Each write sees the table as left by the lower-numbered ports.
- R11: When several read ports detect errors in one cycle, only the lowest-numbered port is reported, and at most one write-back is issued.
- R12: After reset the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | NW | Write valid per port |
| wr_tag | input | NW*TW | Physical register number per write port |
| wr_data | input | NW*DW | Written word per port |
| wr_used | input | NW | Lifetime prediction, upper bit |
| wr_renamed | input | NW | Lifetime prediction, lower bit |
| wr_pin | input | NW | Pin the entry against replacement |
| fr_en | input | 1 | Register freed |
| fr_tag | input | TW | Freed register number |
| rd_en | input | NR | Read valid per port |
| rd_tag | input | NR*TW | Register number per read port |
| rd_data | input | NR*DW | Word returned by the register file per port |
| err_stall | output | 1 | Stall the reading instruction |
| err_flush | output | 1 | Flush from the oldest reader of err_tag |
| err_uncorr | output | 1 | Uncorrectable error detected |
| err_port | output | $clog2(NR) | Reporting read port |
| err_tag | output | TW | Register with the error |
| wb_en | output | 1 | Correction write-back request |
| wb_tag | output | TW | Write-back register number |
| wb_data | output | DW | Corrected word |

## Verification
Two pairs of events can fall in the same cycle. Three writes can compete for victims in a full table, and errors can arrive on several read ports at once. For the first pair, the bench fills the table with known ranks and issues three higher-ranked writes together. It then probes each tag with a single-bit flip and judges which versions became protected and which were evicted. For the second pair, the bench corrupts the data on two or three read ports at once. It then checks that only the lowest erroring port is reported and that an uncorrectable report on that port suppresses the write-back.

// File: rtl/sel_ecc_shadow.sv
module sel_ecc_shadow #(
  parameter int DW = 32,
  parameter int TW = 7,
  parameter int NE = 8,
  parameter int NW = 3,
  parameter int NR = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NW-1:0]          wr_en,
  input  logic [NW*TW-1:0]       wr_tag,
  input  logic [NW*DW-1:0]       wr_data,
  input  logic [NW-1:0]          wr_used,
  input  logic [NW-1:0]          wr_renamed,
  input  logic [NW-1:0]          wr_pin,
  input  logic                   fr_en,
  input  logic [TW-1:0]          fr_tag,
  input  logic [NR-1:0]          rd_en,
  input  logic [NR*TW-1:0]       rd_tag,
  input  logic [NR*DW-1:0]       rd_data,
  output logic                   err_stall,
  output logic                   err_flush,
  output logic                   err_uncorr,
  output logic [$clog2(NR)-1:0]  err_port,
  output logic [TW-1:0]          err_tag,
  output logic                   wb_en,
  output logic [TW-1:0]          wb_tag,
  output logic [DW-1:0]          wb_data
);

  function automatic int npar(int d);
    int p = 1;
    while ((1 << p) < d + p + 1) p++;
    return p;
  endfunction

  localparam int PB = npar(DW);
  localparam int CW = PB + 1;
  localparam int NP = DW + PB;
  localparam int EW = $clog2(NE);
  localparam int RW = $clog2(NR);

  function automatic logic [PB-1:0] hpar(logic [DW-1:0] d);
    logic [PB-1:0] p = '0;
    int k = 0;
    for (int pos = 1; pos <= NP; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        for (int i = 0; i < PB; i++) if (pos[i]) p[i] = p[i] ^ d[k];
        k++;
      end
    end
    return p;
  endfunction

  function automatic logic [DW-1:0] hfix(logic [DW-1:0] d, logic [PB-1:0] s);
    logic [DW-1:0] r = d;
    int k = 0;
    for (int pos = 1; pos <= NP; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (s == PB'(pos)) r[k] = ~r[k];
        k++;
      end
    end
    return r;
  endfunction

  logic [NE-1:0] v_q, pin_q, v_n, pin_n;
  logic [TW-1:0] tag_q [NE];
  logic [TW-1:0] tag_n [NE];
  logic [1:0]    rk_q  [NE];
  logic [1:0]    rk_n  [NE];
  logic [CW-1:0] cd_q  [NE];
  logic [CW-1:0] cd_n  [NE];

  always_comb begin
    v_n = v_q; pin_n = pin_q; tag_n = tag_q; rk_n = rk_q; cd_n = cd_q;
    if (fr_en)
      for (int e = 0; e < NE; e++) if (v_n[e] && tag_n[e] == fr_tag) v_n[e] = 1'b0;
    for (int w = 0; w < NW; w++) begin
      logic          fnd;
      logic [EW-1:0] sel;
      logic [1:0]    rk, best;
      logic [TW-1:0] t;
      logic [DW-1:0] d;
      fnd = 1'b0; sel = '0;
      t = wr_tag[w*TW +: TW];
      d = wr_data[w*DW +: DW];
      rk = {wr_used[w], wr_renamed[w]};
      best = rk;
      for (int e = 0; e < NE; e++)
        if (!fnd && v_n[e] && tag_n[e] == t) begin fnd = 1'b1; sel = EW'(e); end
      for (int e = 0; e < NE; e++)
        if (!fnd && !v_n[e]) begin fnd = 1'b1; sel = EW'(e); end
      if (!fnd)
        for (int e = 0; e < NE; e++)
          if (!pin_n[e] && rk_n[e] < best) begin best = rk_n[e]; sel = EW'(e); end
      if (!fnd && best < rk) fnd = 1'b1;
      if (wr_en[w] && fnd) begin
        v_n[sel]   = 1'b1;
        pin_n[sel] = wr_pin[w];
        tag_n[sel] = t;
        rk_n[sel]  = rk;
        cd_n[sel]  = {^d ^ ^hpar(d), hpar(d)};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0; pin_q <= '0;
      for (int e = 0; e < NE; e++) begin
        tag_q[e] <= '0; rk_q[e] <= '0; cd_q[e] <= '0;
      end
    end else begin
      v_q <= v_n; pin_q <= pin_n; tag_q <= tag_n; rk_q <= rk_n; cd_q <= cd_n;
    end
  end

  always_comb begin
    logic got;
    got = 1'b0;
    err_stall = 1'b0; err_uncorr = 1'b0; err_port = '0; err_tag = '0; wb_data = '0;
    for (int r = 0; r < NR; r++) begin
      logic          hit, ov;
      logic [CW-1:0] c;
      logic [PB-1:0] s;
      logic [DW-1:0] d;
      logic [TW-1:0] t;
      hit = 1'b0; c = '0;
      t = rd_tag[r*TW +: TW];
      d = rd_data[r*DW +: DW];
      for (int e = 0; e < NE; e++)
        if (v_q[e] && tag_q[e] == t) begin hit = 1'b1; c = cd_q[e]; end
      s  = c[PB-1:0] ^ hpar(d);
      ov = c[PB] ^ (^d) ^ (^c[PB-1:0]);
      if (!got && rd_en[r] && hit && (s != '0 || ov)) begin
        got        = 1'b1;
        err_port   = RW'(r);
        err_tag    = t;
        err_uncorr = !ov;
        err_stall  = ov;
        wb_data    = hfix(d, s);
      end
    end
  end

  assign err_flush = err_stall;
  assign wb_en     = err_stall;
  assign wb_tag    = err_tag;

  function automatic logic holds(logic [TW-1:0] t);
    logic h = 1'b0;
    for (int e = 0; e < NE; e++) if (v_q[e] && tag_q[e] == t) h = 1'b1;
    return h;
  endfunction

  function automatic logic dup_tags();
    logic d = 1'b0;
    for (int a = 0; a < NE; a++)
      for (int b = a + 1; b < NE; b++)
        if (v_q[a] && v_q[b] && tag_q[a] == tag_q[b]) d = 1'b1;
    return d;
  endfunction

  p_wb_port_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (rd_en[err_port] && wb_tag == rd_tag[err_port*TW +: TW]));
  p_unc_no_wb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_uncorr |-> (!wb_en && !err_flush));
  p_uniq_tag_r4: assert property (@(posedge clk) disable iff (!rst_n) !dup_tags());
  p_free_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_en && wr_en == '0) |=> !holds($past(fr_tag)));

  for (genvar g = 0; g < NE; g++) begin : g_pin
    p_pin_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (v_q[g] && pin_q[g] && !fr_en) |=> (v_q[g] && tag_q[g] == $past(tag_q[g])));
  end

endmodule

// File: tb/sel_ecc_shadow_tb_top.sv
module sel_ecc_shadow_tb_top;
  localparam int DW = 32, TW = 7, NW = 3, NR = 3;

  logic clk = 0, rst_n = 0;
  logic [NW-1:0] wr_en = '0, wr_used = '0, wr_renamed = '0, wr_pin = '0;
  logic [NW*TW-1:0] wr_tag = '0;
  logic [NW*DW-1:0] wr_data = '0;
  logic fr_en = 0;
  logic [TW-1:0] fr_tag = '0;
  logic [NR-1:0] rd_en = '0;
  logic [NR*TW-1:0] rd_tag = '0;
  logic [NR*DW-1:0] rd_data = '0;
  logic err_stall, err_flush, err_uncorr, wb_en;
  logic [1:0] err_port;
  logic [TW-1:0] err_tag, wb_tag;
  logic [DW-1:0] wb_data;

  int n_chk = 0, n_fail = 0;

  sel_ecc_shadow dut_i (.*);

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] dval(int t);
    return 32'hA5C3_0F1E ^ (t * 32'h0101_0107);
  endfunction

  task automatic chk(logic ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr1(int tag, logic [DW-1:0] d, logic u, logic rn, logic pn);
    @(negedge clk);
    wr_en = 3'b001; wr_tag = '0; wr_tag[TW-1:0] = TW'(tag);
    wr_data = '0; wr_data[DW-1:0] = d;
    wr_used = {2'b0, u}; wr_renamed = {2'b0, rn}; wr_pin = {2'b0, pn};
    @(negedge clk);
    wr_en = '0;
  endtask

  task automatic rd1(int tag, logic [DW-1:0] d);
    @(negedge clk);
    rd_en = 3'b001; rd_tag = '0; rd_tag[TW-1:0] = TW'(tag);
    rd_data = '0; rd_data[DW-1:0] = d;
    #1;
  endtask

  task automatic shielded(int tag, logic exp, string req);
    rd1(tag, dval(tag) ^ 32'h0000_0100);
    chk(err_stall == exp && (!exp || wb_data == dval(tag)), req, err_stall, exp);
    rd_en = '0;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 / R3: empty table after reset
    rd1(3, 32'hFFFF_0000);
    chk(!err_stall && !wb_en && !err_uncorr, "R12", err_stall, 0);
    // R5: first entry taken
    wr1(10, 32'h1234_5678, 0, 0, 0);
    for (int b = 0; b < DW; b++) begin
      rd1(10, 32'h1234_5678 ^ (32'h1 << b));
      chk(err_stall && err_flush && wb_en && wb_tag == 10 && err_tag == 10 &&
          err_port == 0 && !err_uncorr && wb_data == 32'h1234_5678, "R1", wb_data, 32'h1234_5678);
    end
    rd1(10, 32'h1234_5678);
    chk(!err_stall && !err_uncorr && !wb_en, "R3 clean", err_stall, 0);
    for (int b = 0; b < DW - 1; b++) begin
      rd1(10, 32'h1234_5678 ^ (32'h3 << b));
      chk(err_uncorr && !wb_en && !err_stall, "R2", {err_uncorr, wb_en}, 2);
    end
    rd_en = '0;
    // R4: overwrite same tag
    wr1(10, dval(10), 0, 0, 0);
    shielded(10, 1, "R4");
    // fill: pinned 40 rank0 at entry1, 20..25 rank2 at entries 2..7
    wr1(40, dval(40), 0, 0, 1);
    for (int t = 20; t < 26; t++) wr1(t, dval(t), 1, 0, 0);
    for (int t = 20; t < 26; t++) shielded(t, 1, "R5 fill");
    shielded(10, 1, "R4 single entry");
    // R6: rank1 evicts tag10 (rank0)
    wr1(30, dval(30), 0, 1, 0);
    shielded(30, 1, "R6 new");
    shielded(10, 0, "R6 victim");
    // R8: only pinned rank0 below rank1
    wr1(31, dval(31), 0, 1, 0);
    shielded(31, 0, "R8 refused");
    shielded(40, 1, "R8 pinned kept");
    // R6: rank3 evicts lowest rank (30)
    wr1(32, dval(32), 1, 1, 0);
    shielded(32, 1, "R6 rank3");
    shielded(30, 0, "R6 lowest");
    shielded(20, 1, "R6 others kept");
    // R7: equal rank not shielded
    wr1(33, dval(33), 1, 0, 0);
    shielded(33, 0, "R7");
    // R9: free then allocate
    @(negedge clk); fr_en = 1; fr_tag = 21;
    @(negedge clk); fr_en = 0;
    shielded(21, 0, "R9");
    wr1(33, dval(33), 0, 0, 0);
    shielded(33, 1, "R9 reuse");
    // R10: three writes in one cycle
    @(negedge clk);
    wr_en = 3'b111; wr_used = 3'b111; wr_renamed = 3'b111; wr_pin = 3'b000;
    wr_tag = {TW'(52), TW'(51), TW'(50)};
    wr_data = {dval(52), dval(51), dval(50)};
    @(negedge clk); wr_en = '0;
    shielded(50, 1, "R10 p0");
    shielded(51, 1, "R10 p1");
    shielded(52, 1, "R10 p2");
    shielded(33, 0, "R10 ev33");
    shielded(20, 0, "R10 ev20");
    shielded(22, 0, "R10 ev22");
    shielded(23, 1, "R10 kept");
    // R11: errors on ports 1 and 2
    @(negedge clk);
    rd_en = 3'b111; rd_tag = {TW'(52), TW'(51), TW'(50)};
    rd_data = {dval(52) ^ 32'h10, dval(51) ^ 32'h4, dval(50)};
    #1;
    chk(err_port == 1 && wb_tag == 51 && wb_data == dval(51), "R11", err_port, 1);
    // R11: port0 uncorrectable wins over port1
    @(negedge clk);
    rd_data = {dval(52), dval(51) ^ 32'h4, dval(50) ^ 32'h6};
    #1;
    chk(err_port == 0 && err_uncorr && !wb_en, "R11 unc", err_port, 0);
    @(negedge clk); rd_en = '0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule